// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 operands, both single or both double precision, and returns a copy of a 64-bit floating-point status word with a 2-bit condition code written into one of four selectable condition fields. The core of the processor drives the operands, the precision, the field number and the current status word, then pulses `start`. One clock edge later the block presents the new status word together with a one-cycle `done` pulse. The core then writes that word back to its status register.

A compare in which either operand is a NaN is unordered. The selected field is then written to the unordered code. A trap-enable bit in the incoming status word decides what else happens. If the bit is set, the block raises a one-cycle exception request. If the bit is clear, the block sets a sticky accrued-invalid flag in the returned word. Outside the selected field, and outside that flag when it is written, every status bit passes through unchanged.

Top module: `fcmp_cc_unit`

## Requirements
- R1: The condition code is 2'b00 when the operands are equal, 2'b01 when operand A is below operand B, 2'b10 when A is above B, and 2'b11 when the operands are unordered.
- R2: `fld_sel` chooses the destination field. Value 0 writes bits [11:10], 1 writes [33:32], 2 writes [35:34] and 3 writes [37:36]. Bit 0 of the code goes to the lower bit of the field.
- R3: All bits of `status_out` other than the selected field and the accrued-invalid flag (bit 9) equal the `status_in` value sampled with `start`. Bit 9 also passes through unchanged when no flag is written.
- R4: If either operand is a NaN and the trap-enable bit (bit 27 of `status_in`) is 1, `exc_req` is high in the `done` cycle, the field reads 2'b11 and bit 9 passes through unchanged.
- R5: If either operand is a NaN and bit 27 is 0, the field reads 2'b11, bit 9 of `status_out` is 1 and `exc_req` stays low.
- R6: With `dbl_sel`=1 the operands are binary64 values using all 64 bits. With `dbl_sel`=0 they are binary32 values in bits [31:0], and bits [63:32] have no effect on the result.
- R7: Positive zero and negative zero compare as equal.
- R8: Non-NaN values are ordered by sign and magnitude. Any negative value is below any positive value, and of two negative values the one with the larger magnitude is smaller. Infinities and subnormals follow the same rule.
- R9: The edge that samples `start` high updates `status_out` and raises `done` and, where it applies, `exc_req` for exactly the following cycle. `status_out` holds its value while `start` is low.
- R10: While `rst` is high, `status_out`, `done` and `exc_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Compare request strobe |
| dbl_sel | input | 1 | 1 selects double precision, 0 selects single |
| fld_sel | input | 2 | Destination condition field number |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| status_in | input | 64 | Current status word |
| status_out | output | 64 | Updated status word, registered |
| done | output | 1 | One-cycle completion pulse |
| exc_req | output | 1 | One-cycle invalid-operation exception request |

## Verification
A wrong ordering decision or a bad NaN detection shows up in the selected field of `status_out` in the cycle right after `start`. A wrong field position shows up in the same cycle as a corrupted neighbouring field or as damaged pass-through bits, because the status words used in the sweep vary from one compare to the next. A wrong trap or flag decision is visible in that same cycle on `exc_req` or on bit 9, and a missing hold is caught once the inputs change while `start` is low.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

    localparam int XLEN        = 64;
    localparam int FCC0_LSB    = 10;
    localparam int FCC_EXT_SH  = 22;
    localparam int TRAP_EN_BIT = 27;
    localparam int ACC_INV_BIT = 9;

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    typedef struct packed {
        logic        sign;
        logic        nan;
        logic        zero;
        logic [62:0] mag;
    } fp_view_t;

    function automatic int fcc_lsb(input logic [1:0] sel);
        int r;
        if (sel == 2'd0) r = FCC0_LSB;
        else r = FCC0_LSB + FCC_EXT_SH + 2 * (int'(sel) - 1);
        return r;
    endfunction

endpackage

// File: rtl/fcmp_view.sv
module fcmp_view
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [XLEN-1:0] raw,
    output fp_view_t        view
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [W-2:0]      body;

    always_comb begin
        expo      = raw[W-2 -: EXP_W];
        frac      = raw[FRAC_W-1:0];
        body      = raw[W-2:0];
        view.sign = raw[W-1];
        view.nan  = (&expo) && (|frac);
        view.zero = ~|body;
        view.mag  = 63'(body);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_view_t a,
    input  fp_view_t b,
    output cc_e      code,
    output logic     unord
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = a.mag < b.mag;
        mag_eq = a.mag == b.mag;
        unord  = a.nan | b.nan;
        if (unord)                code = CC_UN;
        else if (a.zero && b.zero) code = CC_EQ;
        else if (a.sign != b.sign) code = a.sign ? CC_LT : CC_GT;
        else if (mag_eq)          code = CC_EQ;
        else if (a.sign)          code = mag_lt ? CC_GT : CC_LT;
        else                      code = mag_lt ? CC_LT : CC_GT;
    end
endmodule

// File: rtl/fcmp_merge.sv
module fcmp_merge
    import fcmp_pkg::*;
(
    input  logic [XLEN-1:0] status_in,
    input  logic [1:0]      fld_sel,
    input  cc_e             code,
    input  logic            unord,
    output logic [XLEN-1:0] status_nxt,
    output logic            exc
);
    int lsb;

    always_comb begin
        lsb        = fcc_lsb(fld_sel);
        status_nxt = status_in;
        status_nxt[lsb +: 2] = 2'b00;
        status_nxt[lsb +: 2] = status_nxt[lsb +: 2] | code;
        exc = unord & status_in[TRAP_EN_BIT];
        if (unord && !status_in[TRAP_EN_BIT])
            status_nxt[ACC_INV_BIT] = 1'b1;
    end
endmodule

// File: rtl/fcmp_cc_unit.sv
module fcmp_cc_unit
    import fcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            dbl_sel,
    input  logic [1:0]      fld_sel,
    input  logic [63:0]     op_a,
    input  logic [63:0]     op_b,
    input  logic [63:0]     status_in,
    output logic [63:0]     status_out,
    output logic            done,
    output logic            exc_req
);
    localparam int NOPS = 2;

    logic [XLEN-1:0] ops [NOPS];
    fp_view_t        v_sp [NOPS];
    fp_view_t        v_dp [NOPS];
    fp_view_t        v_sel [NOPS];

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fcmp_view #(.EXP_W(8),  .FRAC_W(23)) u_sp (.raw(ops[i]), .view(v_sp[i]));
        fcmp_view #(.EXP_W(11), .FRAC_W(52)) u_dp (.raw(ops[i]), .view(v_dp[i]));
        assign v_sel[i] = dbl_sel ? v_dp[i] : v_sp[i];
    end

    cc_e             code;
    logic            unord;
    logic [XLEN-1:0] status_nxt;
    logic            exc_nxt;

    fcmp_order u_order (
        .a     (v_sel[0]),
        .b     (v_sel[1]),
        .code  (code),
        .unord (unord)
    );

    fcmp_merge u_merge (
        .status_in  (status_in),
        .fld_sel    (fld_sel),
        .code       (code),
        .unord      (unord),
        .status_nxt (status_nxt),
        .exc        (exc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_out <= '0;
            done       <= 1'b0;
            exc_req    <= 1'b0;
        end else begin
            done    <= start;
            exc_req <= start & exc_nxt;
            if (start) status_out <= status_nxt;
        end
    end
endmodule

// File: rtl/fcmp_cc_unit_chk.sv
module fcmp_cc_unit_chk
    import fcmp_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        dbl_sel,
    input logic [1:0]  fld_sel,
    input logic [63:0] op_a,
    input logic [63:0] op_b,
    input logic [63:0] status_in,
    input logic [63:0] status_out,
    input logic        done,
    input logic        exc_req
);
    logic [1:0]  sel_q;
    logic [63:0] stat_q;
    logic [63:0] keep_mask;
    logic [1:0]  fld_now;
    int          lsb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            stat_q <= '0;
        end else if (start) begin
            sel_q  <= fld_sel;
            stat_q <= status_in;
        end
    end

    always_comb begin
        lsb_q     = fcc_lsb(sel_q);
        keep_mask = '1;
        keep_mask[lsb_q +: 2]   = 2'b00;
        keep_mask[ACC_INV_BIT]  = 1'b0;
        fld_now   = status_out[lsb_q +: 2];
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> done); // R9
    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(start)); // R9
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(status_out)); // R9
    AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> done); // R4
    AST_EXC_FIELD_UNORD: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> fld_now == 2'b11); // R4
    AST_EXC_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> status_out[ACC_INV_BIT] == stat_q[ACC_INV_BIT]); // R4
    AST_FLAG_ON_MASKED_NAN: assert property (@(posedge clk) disable iff (rst)
        (done && fld_now == 2'b11 && !stat_q[TRAP_EN_BIT]) |-> (status_out[ACC_INV_BIT] && !exc_req)); // R5
    AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        done |-> ((status_out ^ stat_q) & keep_mask) == 64'd0); // R3
endmodule

bind fcmp_cc_unit fcmp_cc_unit_chk u_chk (.*);

// File: tb/fcmp_cc_unit_tb.sv
module fcmp_cc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dbl_sel;
    logic [1:0]  fld_sel;
    logic [63:0] op_a, op_b, status_in;
    logic [63:0] status_out;
    logic        done, exc_req;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fcmp_cc_unit u_dut (.*);

    function automatic logic [63:0] pick(input int i, input bit dbl);
        logic [63:0] d [12];
        logic [31:0] s [12];
        d = '{64'h0, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000,
              64'hBFF0_0000_0000_0000, 64'h4000_0000_0000_0000, 64'hC000_0000_0000_0000,
              64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 64'h7FF8_0000_0000_0000,
              64'h7FF0_0000_0000_0001, 64'h0000_0000_0000_0001, 64'hFFF8_0000_0000_0000};
        s = '{32'h0, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000,
              32'hC000_0000, 32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0000,
              32'h7F80_0001, 32'h0000_0001, 32'hFFC0_0000};
        if (dbl) return d[i];
        return {32'h7FF8_0000 ^ 32'(i * 32'h0101_0101), s[i]};
    endfunction

    function automatic logic [1:0] ref_code(input logic [63:0] a, input logic [63:0] b, input bit dbl);
        longint ka, kb;
        bit na, nb;
        if (dbl) begin
            na = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
            nb = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
            ka = a[63] ? -longint'({1'b0, a[62:0]}) : longint'({1'b0, a[62:0]});
            kb = b[63] ? -longint'({1'b0, b[62:0]}) : longint'({1'b0, b[62:0]});
        end else begin
            na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
            nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
            ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
            kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        end
        if (na || nb) return 2'b11;
        if (ka == kb) return 2'b00;
        if (ka < kb)  return 2'b01;
        return 2'b10;
    endfunction

    function automatic int lsb_of(input logic [1:0] f);
        case (f)
            2'd0: return 10;
            2'd1: return 32;
            2'd2: return 34;
            default: return 36;
        endcase
    endfunction

    task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                          input logic [1:0] f, input logic [63:0] st);
        logic [63:0] exp_st;
        logic [1:0]  c;
        bit          nan_hit;
        int          l;
        c = ref_code(a, b, dbl);
        nan_hit = (c == 2'b11);
        l = lsb_of(f);
        exp_st = st;
        exp_st[l +: 2] = c;
        if (nan_hit && !st[27]) exp_st[9] = 1'b1;
        @(negedge clk);
        op_a = a; op_b = b; dbl_sel = dbl; fld_sel = f; status_in = st; start = 1'b1;
        @(posedge clk);
        #1;
        // R1 R2 R3 R6 R7 R8: full status word; R5 flag included
        chk64("R1/R2/R3/R5/R6/R7/R8 status", status_out, exp_st);
        chk1("R9 done", done, 1'b1);
        chk1("R4 exc_req", exc_req, nan_hit && st[27]);
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #100000000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] st;
        logic [63:0] held;
        int n;
        rst = 1'b1; start = 1'b0; dbl_sel = 1'b0; fld_sel = 2'd0;
        op_a = '0; op_b = '0; status_in = '1;
        repeat (3) @(posedge clk);
        #1;
        chk64("R10 status reset", status_out, 64'd0);
        chk1("R10 done reset", done, 1'b0);
        chk1("R10 exc reset", exc_req, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        n = 0;
        for (int p = 0; p < 2; p++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    for (int f = 0; f < 4; f++)
                        for (int t = 0; t < 2; t++) begin
                            n++;
                            st = {32'(n * 32'h9E37_79B9), 32'(n * 32'h85EB_CA6B)} ^ 64'h5A5A_C3C3_0F0F_9696;
                            st[27] = t[0];
                            do_cmp(pick(i, p == 1), pick(j, p == 1), p == 1, f[1:0], st);
                        end

        // R9: hold while idle, done and exc stay low
        held = status_out;
        @(negedge clk);
        status_in = 64'h0123_4567_89AB_CDEF; op_a = 64'h7FF8_0000_0000_0000; fld_sel = 2'd3;
        repeat (3) @(posedge clk);
        #1;
        chk64("R9 hold status", status_out, held);
        chk1("R9 done idle", done, 1'b0);
        chk1("R4 exc idle", exc_req, 1'b0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule